// File: doc/BRIEF.md
# Dual-Mode Boot and Flash Decoder

This block is the address-decode and control glue for a small 8-bit processor with a 16-bit address bus. It supports two boot modes. A mode input is captured once when reset is released. That captured mode decides what the top 4K of the address space reads from and how the external flash is strobed.

In normal mode the processor boots from the external flash. In that mode the flash is read-only and appears only at $F000-$FFFF. In program mode the processor boots from an internal 4K boot ROM instead. The flash then becomes write-only: every processor write to the upper 32K is passed through to it. This lets a loader run the flash command sequence, which writes the command words at $AAAA and $D555, and rewrite the flash in place without taking it out of its socket.

In both modes the block also generates the select strobes for RAM, the I/O page and the serial port. It drives the read-data multiplexer that chooses between ROM data and the external data bus.

Top module: `boot_decode`

## Requirements
- R1: The mode is taken from `boot_sel` at the first rising `clk` edge after `rst_n` goes high. Low selects program mode and high selects normal mode. The captured mode, shown on `prog_mode` (1 means program mode), holds until the next reset, whatever `boot_sel` does meanwhile.
- R2: While `rst_n` is low, `flash_ce_n`, `flash_oe_n` and `flash_we_n` are all high, and `prog_mode` is 0, so the decode follows normal-mode rules.
- R3: In both modes, `ram_sel` is high exactly for $0000-$DFFF and `io_sel` is high exactly for $E000-$EFFF, for reads and writes alike.
- R4: `uart_sel` covers $E400-$E4FF in normal mode and $E400-$EFFF in program mode, for reads and writes.
- R5: In normal mode, `flash_ce_n` is low only for reads (`rw`=1) of $F000-$FFFF. Out of reset, `flash_oe_n` is always low and `flash_we_n` is always high.
- R6: In program mode, reads of $F000-$FFFF raise `rom_sel`, and `rd_data` then returns the ROM byte at offset a (a = addr[11:0]), equal to a[7:0] ^ {a[11:8],a[11:8]} ^ ROM_SEED (default 8'h3C). In every other case `rd_data` equals `ext_data`.
- R7: In program mode, `flash_oe_n` stays high, and `flash_ce_n` is low exactly for writes (`rw`=0) with addr[15]=1.
- R8: `flash_we_n` is low exactly when all of these hold: program mode, out of reset, a write with addr[15]=1, and `phi2` high.
- R9: `flash_addr` always equals addr[14:0], so $AAAA and $D555 reach the flash as 15'h2AAA and 15'h5555.
- R10: Out of reset, every read asserts exactly one of `ram_sel`, `io_sel`, `rom_sel` and an active `flash_ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the mode after reset release |
| rst_n | input | 1 | Active-low reset |
| boot_sel | input | 1 | Mode input: low selects program mode, high selects normal mode |
| addr | input | 16 | CPU address bus |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Data-valid phase of the bus cycle |
| ext_data | input | 8 | Read data from the external bus |
| prog_mode | output | 1 | Captured mode, 1 = program mode |
| ram_sel | output | 1 | RAM select |
| io_sel | output | 1 | I/O page select |
| uart_sel | output | 1 | Serial port select |
| rom_sel | output | 1 | Internal boot ROM read select |
| rd_data | output | 8 | Read data returned to the CPU |
| flash_ce_n | output | 1 | Flash chip select, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_addr | output | 15 | Address to the flash |

## Verification
The assertions check these properties on every clock cycle:
- the mode stays unchanged for the whole time reset stays released;
- the flash strobes are held inactive during reset;
- the flash output enable stays off in program mode;
- a write strobe never appears without a program-mode write chip select;
- the serial select always lies inside the I/O page;
- exactly one read source is chosen per read.

The exact address boundaries need the bench's scenarios, since the assertions cannot show them on their own:
- RAM/I/O edges at $DFFF/$E000;
- the serial window edges at $E3FF, $E4FF and $E500;
- the 32K shadow-write edge at $7FFF/$8000.

The same holds for the ROM contents, the gating of the write strobe by the data phase, and the fact that `boot_sel` is ignored after capture.

// File: rtl/boot_decode.sv
module boot_decode #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [7:0]  ROM_SEED = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_sel,
  input  logic [AW-1:0] addr,
  input  logic          rw,
  input  logic          phi2,
  input  logic [DW-1:0] ext_data,
  output logic          prog_mode,
  output logic          ram_sel,
  output logic          io_sel,
  output logic          uart_sel,
  output logic          rom_sel,
  output logic [DW-1:0] rd_data,
  output logic          flash_ce_n,
  output logic          flash_oe_n,
  output logic          flash_we_n,
  output logic [AW-2:0] flash_addr
);
  localparam int PW = 4;

  logic          armed;
  logic          prog_q;
  logic [PW-1:0] page;
  logic          top_pg, io_pg, hi_half, wr_shadow;
  logic [DW-1:0] rom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b1;
      prog_q <= 1'b0;
    end else if (armed) begin
      armed  <= 1'b0;
      prog_q <= ~boot_sel;
    end
  end

  assign prog_mode = prog_q;
  assign page      = addr[AW-1 -: PW];
  assign top_pg    = page == 4'hF;
  assign io_pg     = page == 4'hE;
  assign hi_half   = addr[AW-1];
  assign wr_shadow = prog_q && !rw && hi_half;

  assign ram_sel  = page < 4'hE;
  assign io_sel   = io_pg;
  assign uart_sel = io_pg && (prog_q ? (addr[11:8] >= 4'h4) : (addr[11:8] == 4'h4));
  assign rom_sel  = prog_q && rw && top_pg;

  always_comb rom_q = addr[7:0] ^ {addr[11:8], addr[11:8]} ^ ROM_SEED;

  assign rd_data    = rom_sel ? rom_q : ext_data;
  assign flash_addr = addr[AW-2:0];

  assign flash_ce_n = !(rst_n && (prog_q ? wr_shadow : (rw && top_pg)));
  assign flash_oe_n = !(rst_n && !prog_q);
  assign flash_we_n = !(rst_n && wr_shadow && phi2);
endmodule

// File: rtl/boot_decode_chk.sv
module boot_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rw,
  input logic        prog_mode,
  input logic        ram_sel,
  input logic        io_sel,
  input logic        uart_sel,
  input logic        rom_sel,
  input logic        flash_ce_n,
  input logic        flash_oe_n,
  input logic        flash_we_n
);
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> $stable(prog_mode));

  assert_reset_quiet_R2: assert property (@(posedge clk)
    !rst_n |-> (flash_ce_n && flash_oe_n && flash_we_n && !prog_mode));

  assert_uart_in_io_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uart_sel |-> io_sel);

  assert_no_flash_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |-> flash_oe_n);

  assert_we_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> (!flash_ce_n && !rw && prog_mode));

  assert_one_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rw |-> $onehot({ram_sel, io_sel, rom_sel, !flash_ce_n}));
endmodule

bind boot_decode boot_decode_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rw(rw), .prog_mode(prog_mode),
  .ram_sel(ram_sel), .io_sel(io_sel), .uart_sel(uart_sel), .rom_sel(rom_sel),
  .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
);

// File: tb/test_boot_decode.sv
module test_boot_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_sel = 1'b1;
  logic [15:0] addr = '0;
  logic        rw = 1'b1;
  logic        phi2 = 1'b0;
  logic [7:0]  ext_data = 8'hA5;
  logic        prog_mode, ram_sel, io_sel, uart_sel, rom_sel;
  logic [7:0]  rd_data;
  logic        flash_ce_n, flash_oe_n, flash_we_n;
  logic [14:0] flash_addr;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  boot_decode i_boot_decode (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .addr(addr), .rw(rw),
    .phi2(phi2), .ext_data(ext_data), .prog_mode(prog_mode),
    .ram_sel(ram_sel), .io_sel(io_sel), .uart_sel(uart_sel), .rom_sel(rom_sel),
    .rd_data(rd_data), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .flash_we_n(flash_we_n), .flash_addr(flash_addr)
  );

  // {addr, rw, normal{ram,io,uart,rom,ce}, program{ram,io,uart,rom,ce}}
  localparam logic [26:0] VEC [16] = '{
    {16'h0000, 1'b1, 5'b10000, 5'b10000},
    {16'h7FFF, 1'b0, 5'b10000, 5'b10000},
    {16'h8000, 1'b0, 5'b10000, 5'b10001},
    {16'hAAAA, 1'b0, 5'b10000, 5'b10001},
    {16'hD555, 1'b0, 5'b10000, 5'b10001},
    {16'hDFFF, 1'b1, 5'b10000, 5'b10000},
    {16'hE000, 1'b1, 5'b01000, 5'b01000},
    {16'hE400, 1'b1, 5'b01100, 5'b01100},
    {16'hE4FF, 1'b0, 5'b01100, 5'b01101},
    {16'hE500, 1'b1, 5'b01000, 5'b01100},
    {16'hEFFF, 1'b0, 5'b01000, 5'b01101},
    {16'hE3FF, 1'b1, 5'b01000, 5'b01000},
    {16'hF000, 1'b1, 5'b00001, 5'b00010},
    {16'hFFFC, 1'b1, 5'b00001, 5'b00010},
    {16'hF123, 1'b0, 5'b00000, 5'b00001},
    {16'h8000, 1'b1, 5'b10000, 5'b10000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_ref(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst_n = 1'b0;
    boot_sel = sel;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic walk(input logic prg);
    for (int i = 0; i < 16; i++) begin
      logic [4:0] e;
      e = prg ? VEC[i][4:0] : VEC[i][9:5];
      @(negedge clk);
      addr = VEC[i][26:11];
      rw   = VEC[i][10];
      phi2 = 1'b1;
      #1;
      chk("R3/R4/R5/R6/R7 selects", {ram_sel, io_sel, uart_sel, rom_sel, !flash_ce_n},
          e);
      chk("R5/R7 oe", flash_oe_n, prg);
      chk("R8 we", !flash_we_n, prg & e[0]);
      chk("R9 flash_addr", flash_addr, addr[14:0]);
      chk("R6 rd_data", rd_data, e[1] ? rom_ref(addr[11:0]) : ext_data);
      if (rw) chk("R10 one source", $countones({ram_sel, io_sel, rom_sel, !flash_ce_n}), 1);
    end
  endtask

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    addr = 16'hF000;
    rw   = 1'b1;
    #3;
    chk("R2 strobes in reset", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
    chk("R2 normal default", prog_mode, 1'b0);

    do_reset(1'b1);
    chk("R1 normal captured", prog_mode, 1'b0);
    walk(1'b0);

    do_reset(1'b0);
    chk("R1 program captured", prog_mode, 1'b1);
    walk(1'b0 | 1'b1);

    @(negedge clk);
    boot_sel = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 boot_sel ignored after capture", prog_mode, 1'b1);

    addr = 16'hAAAA; rw = 1'b0; phi2 = 1'b0;
    #1;
    chk("R8 we idle outside phi2", flash_we_n, 1'b1);
    chk("R7 ce still active for write", flash_ce_n, 1'b0);
    phi2 = 1'b1;
    #1;
    chk("R8 we during phi2", flash_we_n, 1'b0);
    chk("R9 AAAA maps to 2AAA", flash_addr, 15'h2AAA);

    addr = 16'hFABC; rw = 1'b1; ext_data = 8'h11;
    #1;
    chk("R6 rom byte", rd_data, rom_ref(12'hABC));
    addr = 16'h1234;
    #1;
    chk("R6 ext path", rd_data, 8'h11);

    @(negedge clk);
    rst_n = 1'b0;
    addr = 16'hD555; rw = 1'b0; phi2 = 1'b1;
    #1;
    chk("R2 strobes forced in reset", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
    chk("R2 mode cleared in reset", prog_mode, 1'b0);

    do_reset(1'b1);
    addr = 16'hD555; rw = 1'b0; phi2 = 1'b1;
    #1;
    chk("R5 normal write no strobe", {flash_ce_n, flash_we_n, flash_oe_n}, 3'b110);
    chk("R9 D555 maps to 5555", flash_addr, 15'h5555);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule